// File: doc/BRIEF.md
# Variable-Length Instruction Splitter

This block sits behind an instruction fetch path and turns a flat stream of 16-bit code halfwords into whole instructions. Instructions in this encoding are one to five halfwords long. The length is carried in a prefix-free code at the top of the first halfword. The splitter reads that code, gathers the right number of halfwords, and presents one complete instruction per output beat. Each instruction follows the previous one directly, with no gaps between them.

Halfwords arrive through a valid/ready handshake, and instructions leave through another one. An output beat carries three things: an 80-bit payload with the first halfword in the top bits, the length in halfwords, and the byte address of the instruction's first halfword. A flush input abandons whatever is in flight and restarts alignment at a given address, as needed after a taken branch or a redirect.

Top module: `vl_insn_splitter`

## Requirements
- R1: A first halfword whose bit 15 is 1 starts a 2-halfword (32-bit) instruction.
- R2: A first halfword with bit 15 = 0 and bits 14:13 other than 2'b11 starts a 1-halfword instruction.
- R3: A first halfword with bits 15:13 = 3'b011 starts a 3-halfword instruction when bits 12:11 differ from 2'b11. It starts a 4-halfword instruction when bits 15:10 = 6'b011110, and a 5-halfword instruction when bits 15:10 = 6'b011111.
- R4: `ins_data` holds the instruction's halfwords in order: the first in bits 79:64, the second in bits 63:48, and so on down. Bits below the last halfword are zero. `ins_len` gives the halfword count, from 1 to 5.
- R5: `ins_addr` is the byte address of the instruction's first halfword. Each accepted halfword advances the fetch address by 2. After reset the first halfword sits at address 0.
- R6: A halfword is taken on a clock edge where `hw_valid` and `hw_ready` are both high. The instruction appears on `ins_valid` right after the edge that takes its last halfword. It stays unchanged until an edge with `ins_ready` high.
- R7: While `ins_valid` is high and `ins_ready` is low, `hw_ready` is low.
- R8: While `flush` is high, `hw_ready` is low. After a flush edge, any partly gathered instruction and any waiting output are dropped, so `ins_valid` is low. The next halfword taken starts a new instruction at `flush_addr`.
- R9: After reset, `ins_valid` is low and `hw_ready` is high.
- R10: With `hw_valid` and `ins_ready` held high and no flush, one halfword is taken every cycle with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop in-flight state and realign |
| flush_addr | input | ADDR_W | Byte address of the next halfword after a flush |
| hw_valid | input | 1 | Incoming halfword is valid |
| hw_ready | output | 1 | Splitter can take a halfword |
| hw_data | input | 16 | Incoming code halfword, bit 15 first in program order |
| ins_valid | output | 1 | A complete instruction is presented |
| ins_ready | input | 1 | Consumer takes the presented instruction |
| ins_data | output | 80 | Instruction payload, left-aligned |
| ins_len | output | 3 | Instruction length in halfwords (1 to 5) |
| ins_addr | output | ADDR_W | Byte address of the instruction's first halfword |

## Verification
Two events can land on the same edge. A flush can arrive in the very cycle that offers the last halfword of an instruction. A stalled output can also meet a completing gather. In the first case the bench offers the completing halfword together with `flush`. It then checks that the halfword is refused, that nothing is emitted for the cut instruction, and that the next instruction carries the flush address and only the new halfwords. In the second case the bench releases `ins_ready` on an edge where another instruction completes. It then checks that the next beat is the new instruction and not a repeat of the old one. A sweep covers all 64 values of the six length bits and runs twice: once at full rate, and once with gaps in input valid and output ready.

// File: rtl/vls_pkg.sv
package vls_pkg;
    localparam int HW_W   = 16;
    localparam int MAX_HW = 5;
    localparam int PAY_W  = HW_W * MAX_HW;
    localparam int LEN_W  = $clog2(MAX_HW + 1);
    localparam int TAG_W  = 6;
endpackage

// File: rtl/vls_len_class.sv
module vls_len_class
    import vls_pkg::*;
(
    input  logic [TAG_W-1:0] lead_bits,
    output logic [LEN_W-1:0] hw_count
);
    // lead_bits[TAG_W-1] is bit 15 of the first halfword
    always_comb begin
        if (lead_bits[5]) begin
            hw_count = LEN_W'(2);
        end else if (lead_bits[4:3] != 2'b11) begin
            hw_count = LEN_W'(1);
        end else if (lead_bits[2:1] != 2'b11) begin
            hw_count = LEN_W'(3);
        end else if (!lead_bits[0]) begin
            hw_count = LEN_W'(4);
        end else begin
            hw_count = LEN_W'(5);
        end
    end
endmodule

// File: rtl/vls_slot_merge.sv
module vls_slot_merge
    import vls_pkg::*;
(
    input  logic [PAY_W-1:0] cur_buf,
    input  logic [LEN_W-1:0] slot_idx,
    input  logic             fresh,
    input  logic [HW_W-1:0]  new_hw,
    output logic [PAY_W-1:0] merged
);
    // slot 0 is the most significant halfword of the payload
    for (genvar s = 0; s < MAX_HW; s++) begin : g_slot
        localparam int HI = PAY_W - 1 - s * HW_W;
        assign merged[HI -: HW_W] =
            (slot_idx == LEN_W'(s)) ? new_hw :
            fresh                   ? '0     :
                                      cur_buf[HI -: HW_W];
    end
endmodule

// File: rtl/vl_insn_splitter.sv
module vl_insn_splitter
    import vls_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [ADDR_W-1:0] flush_addr,
    input  logic              hw_valid,
    output logic              hw_ready,
    input  logic [HW_W-1:0]   hw_data,
    output logic              ins_valid,
    input  logic              ins_ready,
    output logic [PAY_W-1:0]  ins_data,
    output logic [LEN_W-1:0]  ins_len,
    output logic [ADDR_W-1:0] ins_addr
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(HW_W / 8);

    typedef struct packed {
        logic [PAY_W-1:0]  gbuf;
        logic [LEN_W-1:0]  gcnt;
        logic [LEN_W-1:0]  glen;
        logic [ADDR_W-1:0] gaddr;
        logic [ADDR_W-1:0] naddr;
        logic              ovld;
        logic [PAY_W-1:0]  odata;
        logic [LEN_W-1:0]  olen;
        logic [ADDR_W-1:0] oaddr;
    } st_t;

    st_t q, d;

    logic [LEN_W-1:0] cls_len;
    logic [LEN_W-1:0] cur_len;
    logic [PAY_W-1:0] merged;
    logic             first_hw;
    logic             out_free;
    logic             take;

    vls_len_class u_class (
        .lead_bits (hw_data[HW_W-1 -: TAG_W]),
        .hw_count  (cls_len)
    );

    vls_slot_merge u_merge (
        .cur_buf  (q.gbuf),
        .slot_idx (q.gcnt),
        .fresh    (first_hw),
        .new_hw   (hw_data),
        .merged   (merged)
    );

    assign first_hw = (q.gcnt == '0);
    assign cur_len  = first_hw ? cls_len : q.glen;
    assign out_free = !q.ovld || ins_ready;
    assign hw_ready = !flush && out_free;
    assign take     = hw_valid && hw_ready;

    always_comb begin
        d = q;
        if (q.ovld && ins_ready) begin
            d.ovld = 1'b0;
        end
        if (take) begin
            d.gbuf  = merged;
            d.naddr = q.naddr + STEP;
            if (first_hw) begin
                d.gaddr = q.naddr;
                d.glen  = cls_len;
            end
            if (LEN_W'(q.gcnt + 1'b1) == cur_len) begin
                d.ovld  = 1'b1;
                d.odata = merged;
                d.olen  = cur_len;
                d.oaddr = first_hw ? q.naddr : q.gaddr;
                d.gcnt  = '0;
            end else begin
                d.gcnt  = LEN_W'(q.gcnt + 1'b1);
            end
        end
        if (flush) begin
            d.gcnt  = '0;
            d.gbuf  = '0;
            d.ovld  = 1'b0;
            d.naddr = flush_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.naddr <= RESET_ADDR;
        end else begin
            q <= d;
        end
    end

    assign ins_valid = q.ovld;
    assign ins_data  = q.odata;
    assign ins_len   = q.olen;
    assign ins_addr  = q.oaddr;
endmodule

// File: rtl/vls_checker.sv
module vls_checker
    import vls_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              hw_ready,
    input logic              ins_valid,
    input logic              ins_ready,
    input logic [PAY_W-1:0]  ins_data,
    input logic [LEN_W-1:0]  ins_len,
    input logic [ADDR_W-1:0] ins_addr
);
    p_len_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |-> (ins_len >= LEN_W'(1)) && (ins_len <= LEN_W'(MAX_HW)));

    p_tail_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && ins_len == LEN_W'(1) |-> ins_data[PAY_W-HW_W-1:0] == '0);

    p_word_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && ins_data[PAY_W-1] |-> ins_len == LEN_W'(2));

    p_half_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && !ins_data[PAY_W-1] && ins_data[PAY_W-2 -: 2] != 2'b11
        |-> ins_len == LEN_W'(1));

    p_long_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && ins_data[PAY_W-1 -: 3] == 3'b011 |-> ins_len >= LEN_W'(3));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && !ins_ready && !flush
        |=> ins_valid && $stable(ins_data) && $stable(ins_len) && $stable(ins_addr));

    p_backpressure_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && !ins_ready |-> !hw_ready);

    p_flush_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !hw_ready);

    p_flush_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !ins_valid);
endmodule

bind vl_insn_splitter vls_checker #(.ADDR_W(ADDR_W)) u_vls_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .hw_ready  (hw_ready),
    .ins_valid (ins_valid),
    .ins_ready (ins_ready),
    .ins_data  (ins_data),
    .ins_len   (ins_len),
    .ins_addr  (ins_addr)
);

// File: tb/vl_insn_splitter_bench.sv
`timescale 1ns/1ps
module vl_insn_splitter_bench;
    localparam int NI   = 64;
    localparam int MAXS = NI * 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [31:0] flush_addr = '0;
    logic        hw_valid = 1'b0;
    logic        hw_ready;
    logic [15:0] hw_data = '0;
    logic        ins_valid;
    logic        ins_ready = 1'b1;
    logic [79:0] ins_data;
    logic [2:0]  ins_len;
    logic [31:0] ins_addr;

    always #10 clk = ~clk;

    vl_insn_splitter u_vl_insn_splitter (
        .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
        .hw_valid(hw_valid), .hw_ready(hw_ready), .hw_data(hw_data),
        .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_data(ins_data),
        .ins_len(ins_len), .ins_addr(ins_addr)
    );

    int total = 0;
    int fails = 0;

    logic [15:0] stream  [MAXS];
    logic [79:0] exp_dat [NI];
    logic [2:0]  exp_len [NI];
    int          exp_off [NI];
    int          nhw;

    logic        obs_valid, obs_hwready;
    logic [79:0] obs_data;
    logic [2:0]  obs_len;
    logic [31:0] obs_addr;

    task automatic chk(input bit ok, input string req, input logic [79:0] act,
                       input logic [79:0] expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    function automatic logic [2:0] len_of(input logic [5:0] k);
        if (k[5]) return 3'd2;
        if (k[4:3] != 2'b11) return 3'd1;
        if (k[2:1] != 2'b11) return 3'd3;
        return k[0] ? 3'd5 : 3'd4;
    endfunction

    function automatic string tag_of(input logic [2:0] l);
        if (l == 3'd2) return "R1";
        if (l == 3'd1) return "R2";
        return "R3";
    endfunction

    task automatic build();
        int p = 0;
        for (int k = 0; k < NI; k++) begin
            logic [2:0] l = len_of(6'(k));
            exp_len[k] = l;
            exp_off[k] = 2 * p;
            exp_dat[k] = '0;
            for (int j = 0; j < int'(l); j++) begin
                logic [15:0] h;
                if (j == 0) h = {6'(k), 10'(k * 13 + 1)};
                else        h = 16'(k * 257 + j * 4099);
                stream[p] = h;
                exp_dat[k] = exp_dat[k] | (80'(h) << (64 - 16 * j));
                p++;
            end
        end
        nhw = p;
    endtask

    // drive at falling edge, observe settled values, then let the rising edge act
    task automatic step(input bit hv, input logic [15:0] hd, input bit ir,
                        input bit fl, input logic [31:0] fa);
        @(negedge clk);
        hw_valid = hv; hw_data = hd; ins_ready = ir; flush = fl; flush_addr = fa;
        #1;
        obs_valid = ins_valid; obs_hwready = hw_ready; obs_data = ins_data;
        obs_len = ins_len; obs_addr = ins_addr;
        @(posedge clk);
    endtask

    task automatic run_stream(input bit pressured, input logic [31:0] base);
        int idx = 0, oidx = 0, cyc = 0, stalls = 0;
        bit prev_hold = 0;
        logic [79:0] prev_data = '0;
        step(0, '0, 1, 1, base);
        while (oidx < NI && cyc < 5000) begin
            bit hv = (idx < nhw) && (!pressured || (cyc % 5 != 2));
            bit ir = !pressured || (cyc % 3 != 0);
            step(hv, hv ? stream[idx] : 16'h0, ir, 0, '0);
            if (prev_hold)
                chk(obs_valid && obs_data == prev_data, "R6 hold", obs_data, prev_data);
            if (obs_valid && !ir)
                chk(!obs_hwready, "R7 backpressure", 80'(obs_hwready), 80'(0));
            if (!pressured && hv && !obs_hwready) stalls++;
            if (obs_valid && ir) begin
                chk(obs_len == exp_len[oidx], tag_of(exp_len[oidx]),
                    80'(obs_len), 80'(exp_len[oidx]));
                chk(obs_data == exp_dat[oidx], "R4 payload", obs_data, exp_dat[oidx]);
                chk(obs_addr == base + 32'(exp_off[oidx]), "R5 address",
                    80'(obs_addr), 80'(base + 32'(exp_off[oidx])));
                oidx++;
            end
            if (hv && obs_hwready) idx++;
            prev_hold = obs_valid && !ir;
            prev_data = obs_data;
            cyc++;
        end
        chk(oidx == NI, "R6 all instructions delivered", 80'(oidx), 80'(NI));
        if (!pressured) begin
            chk(stalls == 0, "R10 no stall", 80'(stalls), 80'(0));
            chk(cyc == nhw + 1, "R10 one halfword per cycle", 80'(cyc), 80'(nhw + 1));
        end
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog R6: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        build();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!ins_valid, "R9 ins_valid after reset", 80'(ins_valid), 80'(0));
        chk(hw_ready, "R9 hw_ready after reset", 80'(hw_ready), 80'(1));

        // R5 reset address: a 1-halfword instruction straight after reset
        step(1, 16'h0042, 1, 0, '0);
        step(0, '0, 1, 0, '0);
        chk(obs_valid && obs_addr == 32'h0, "R5 reset address", 80'(obs_addr), 80'(0));
        chk(obs_data == {16'h0042, 64'h0}, "R4 single payload", obs_data,
            {16'h0042, 64'h0});

        run_stream(0, 32'h0000_0100);
        run_stream(1, 32'h0000_1000);

        // R8: flush cuts a partly gathered 5-halfword instruction
        step(1, 16'h7C00, 1, 0, '0);
        step(1, 16'h1111, 1, 0, '0);
        step(1, 16'h2222, 1, 0, '0);
        step(1, 16'h3333, 1, 1, 32'h2000);
        chk(!obs_hwready, "R8 hw_ready low in flush", 80'(obs_hwready), 80'(0));
        step(1, 16'h0123, 1, 0, '0);
        chk(!obs_valid, "R8 nothing after cut", 80'(obs_valid), 80'(0));
        step(0, '0, 1, 0, '0);
        chk(obs_valid && obs_len == 3'd1, "R8 new instruction length", 80'(obs_len), 80'(1));
        chk(obs_addr == 32'h2000, "R8 flush address", 80'(obs_addr), 80'(32'h2000));
        chk(obs_data == {16'h0123, 64'h0}, "R8 fresh payload", obs_data, {16'h0123, 64'h0});

        // R7 / R8: flush drops a stalled output
        step(1, 16'h0456, 0, 0, '0);
        step(0, '0, 0, 0, '0);
        chk(obs_valid && !obs_hwready, "R7 stalled output holds input",
            80'(obs_hwready), 80'(0));
        step(0, '0, 0, 1, 32'h3000);
        step(0, '0, 0, 0, '0);
        chk(!obs_valid, "R8 pending output dropped", 80'(obs_valid), 80'(0));

        // R8: flush in the same cycle as a completing halfword
        step(1, 16'h8000, 1, 0, '0);
        step(1, 16'hBEEF, 1, 1, 32'h4000);
        chk(!obs_hwready, "R8 completing halfword refused", 80'(obs_hwready), 80'(0));
        step(1, 16'h8001, 1, 0, '0);
        chk(!obs_valid, "R8 no output for cut instruction", 80'(obs_valid), 80'(0));
        step(1, 16'h5555, 1, 0, '0);
        chk(!obs_valid, "R6 not before last halfword", 80'(obs_valid), 80'(0));
        step(0, '0, 1, 0, '0);
        chk(obs_valid && obs_len == 3'd2, "R1 after flush", 80'(obs_len), 80'(2));
        chk(obs_data == {16'h8001, 16'h5555, 48'h0}, "R4 after flush", obs_data,
            {16'h8001, 16'h5555, 48'h0});
        chk(obs_addr == 32'h4000, "R5 after flush", 80'(obs_addr), 80'(32'h4000));

        // R6: stalled output released on the edge another instruction completes
        step(1, 16'h0011, 0, 0, '0);
        step(1, 16'h0022, 1, 0, '0);
        chk(obs_valid && obs_data == {16'h0011, 64'h0}, "R6 first beat", obs_data,
            {16'h0011, 64'h0});
        step(0, '0, 1, 0, '0);
        chk(obs_valid && obs_data == {16'h0022, 64'h0}, "R6 second beat", obs_data,
            {16'h0022, 64'h0});
        chk(obs_addr == 32'h4006, "R5 second beat address", 80'(obs_addr), 80'(32'h4006));

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule